// File: doc/BRIEF.md
# Dual-Port RAM with Collision Flags and Mailboxes

A synchronous 1024-word by 8-bit memory with two fully independent access ports, called left and right. Each port has its own select, write strobe, output gate, address and data buses. Either port can read or write any word in any clock cycle. Read data is registered and appears one clock after the request.

When both ports select the same word in one cycle and at least one of them writes, the block flags a collision and sends a busy indication to exactly one of them. A port that already held the word in the previous cycle keeps it, and the newcomer is flagged. When both ports arrive together, the left port wins. A flagged port has its write dropped and its read result marked invalid. The top two words of the array also serve as mailboxes. A write by one port to its partner's mailbox raises the partner's interrupt flag, and the partner clears it by reading that word.

A mode input sets how the busy signal is handled. In master mode the block drives busy outputs from its own collision logic. In slave mode it ignores that logic and obeys busy inputs from a master device, so that several devices can be placed side by side to build a wider word.

Top module: `dpram_mailbox`

## Requirements
- R1: The array holds 1024 words of 8 bits, addressed by 10 bits on each port. A word written through either port reads back unchanged through either port, and accesses to different words in the same cycle do not interfere.
- R2: A read request (select high, write strobe low, output gate high, not blocked) at a clock edge makes the port's valid output 1 and its data output equal to the addressed word, both held for the cycle after that edge.
- R3: Two reads of the same word in the same cycle raise no busy flag, and both return valid data.
- R4: In master mode, busy is combinational and holds in the cycle of the collision. A collision is both ports selected, equal addresses, and at least one write strobe. If neither port held that address in the previous cycle, only the right busy output is 1.
- R5: A port "holds" a word when it was selected on the same address in the previous cycle. On a collision where the right port holds the word and the left port does not, only the left busy output is 1.
- R6: A port whose busy is in effect does not modify memory, and its valid output is 0 in the following cycle.
- R7: A write by the right port to address 0x3FF sets the left interrupt flag at that edge. An accepted read of 0x3FF by the left port clears it.
- R8: A write by the left port to address 0x3FE sets the right interrupt flag at that edge. An accepted read of 0x3FE by the right port clears it.
- R9: With select low, a port writes nothing, raises no busy flag and has valid 0. With output gate low, valid is 0. Whenever valid is 0 the data output is 0x00.
- R10: With slave_mode = 1, both busy outputs stay 0. Each busy input blocks that port's write and invalidates its read. With slave_mode = 0, the busy inputs have no effect.
- R11: A synchronous reset clears both interrupt flags and both valid outputs. Memory contents survive reset.
- R12: If both ports write the same word in the same cycle while neither is blocked (possible only in slave mode), the left port's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slave_mode | input | 1 | 1: obey busy inputs; 0: generate busy internally |
| l_cs | input | 1 | Left port select |
| l_we | input | 1 | Left write strobe (1 write, 0 read) |
| l_oe | input | 1 | Left output gate |
| l_addr | input | 10 | Left word address |
| l_wdata | input | 8 | Left write data |
| l_rdata | output | 8 | Left read data, 0 when not valid |
| l_rvalid | output | 1 | Left read data valid |
| l_busy_o | output | 1 | Left collision flag (master mode) |
| l_busy_i | input | 1 | Left busy from a master (slave mode) |
| l_irq | output | 1 | Left mailbox interrupt flag |
| r_cs | input | 1 | Right port select |
| r_we | input | 1 | Right write strobe (1 write, 0 read) |
| r_oe | input | 1 | Right output gate |
| r_addr | input | 10 | Right word address |
| r_wdata | input | 8 | Right write data |
| r_rdata | output | 8 | Right read data, 0 when not valid |
| r_rvalid | output | 1 | Right read data valid |
| r_busy_o | output | 1 | Right collision flag (master mode) |
| r_busy_i | input | 1 | Right busy from a master (slave mode) |
| r_irq | output | 1 | Right mailbox interrupt flag |

## Verification
The properties assume that every input is a known value at each rising edge and that slave_mode changes only between accesses, never within a collision that is being checked. The mailbox-clear property also assumes that no write to the same mailbox word lands in the same cycle. The directed tasks keep to these assumptions. They change inputs one time unit after a rising edge, set the mode only while both ports are idle, and never put a mailbox write and a mailbox read in the same cycle.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  localparam int NPORT = 2;
  localparam int PL = 0;
  localparam int PR = 1;

  // Mailbox word that signals port k: top word for left, next one down for right.
  function automatic logic [9:0] mbox_addr(input int k);
    return 10'h3FF - 10'(k);
  endfunction

  // A collision needs both selects, equal addresses and at least one write.
  function automatic logic collides(input logic a_cs, input logic a_we,
                                    input logic [9:0] a_ad,
                                    input logic b_cs, input logic b_we,
                                    input logic [9:0] b_ad);
    return a_cs && b_cs && (a_ad == b_ad) && (a_we || b_we);
  endfunction
endpackage

// File: rtl/dpram_arbiter.sv
module dpram_arbiter #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          slave_mode,
  input  logic          l_cs,
  input  logic          l_we,
  input  logic [AW-1:0] l_addr,
  input  logic          r_cs,
  input  logic          r_we,
  input  logic [AW-1:0] r_addr,
  input  logic          l_busy_i,
  input  logic          r_busy_i,
  output logic          l_busy_o,
  output logic          r_busy_o,
  output logic          l_block,
  output logic          r_block
);
  logic          l_held_q, r_held_q;
  logic [AW-1:0] l_addr_q, r_addr_q;
  logic          l_cont, r_cont, clash, left_loses, right_loses;

  always_ff @(posedge clk) begin
    if (rst) begin
      l_held_q <= 1'b0;
      r_held_q <= 1'b0;
      l_addr_q <= '0;
      r_addr_q <= '0;
    end else begin
      l_held_q <= l_cs;
      r_held_q <= r_cs;
      l_addr_q <= l_addr;
      r_addr_q <= r_addr;
    end
  end

  always_comb begin
    l_cont      = l_held_q && (l_addr_q == l_addr);
    r_cont      = r_held_q && (r_addr_q == r_addr);
    clash       = l_cs && r_cs && (l_addr == r_addr) && (l_we || r_we);
    left_loses  = clash && r_cont && !l_cont;
    right_loses = clash && !left_loses;
    l_busy_o    = !slave_mode && left_loses;
    r_busy_o    = !slave_mode && right_loses;
    l_block     = slave_mode ? l_busy_i : left_loses;
    r_block     = slave_mode ? r_busy_i : right_loses;
  end
endmodule

// File: rtl/dpram_core.sv
module dpram_core #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          l_wr,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  input  logic          r_wr,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] l_word,
  output logic [DW-1:0] r_word
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  // The left write comes last, so it wins when both hit one word.
  always_ff @(posedge clk) begin
    if (r_wr) mem[r_addr] <= r_wdata;
    if (l_wr) mem[l_addr] <= l_wdata;
  end

  assign l_word = mem[l_addr];
  assign r_word = mem[r_addr];
endmodule

// File: rtl/dpram_rdport.sv
module dpram_rdport #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_req,
  input  logic [DW-1:0] word,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  logic [DW-1:0] word_q;
  logic          vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      word_q <= '0;
    end else begin
      vld_q  <= rd_req;
      word_q <= rd_req ? word : '0;
    end
  end

  assign rvalid = vld_q;
  assign rdata  = vld_q ? word_q : '0;
endmodule

// File: rtl/dpram_mbox_flag.sv
module dpram_mbox_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)        flag <= 1'b0;
    else if (set_i) flag <= 1'b1;
    else if (clr_i) flag <= 1'b0;
  end
endmodule

// File: rtl/dpram_mailbox.sv
module dpram_mailbox
  import dpram_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          slave_mode,
  input  logic          l_cs,
  input  logic          l_we,
  input  logic          l_oe,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          l_rvalid,
  output logic          l_busy_o,
  input  logic          l_busy_i,
  output logic          l_irq,
  input  logic          r_cs,
  input  logic          r_we,
  input  logic          r_oe,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  output logic          r_rvalid,
  output logic          r_busy_o,
  input  logic          r_busy_i,
  output logic          r_irq
);
  // Named internal events, indexed PL / PR.
  logic [NPORT-1:0]          blk, wr_en, rd_en, rd_req, irq;
  logic [NPORT-1:0][AW-1:0]  addr;
  logic [NPORT-1:0][DW-1:0]  word, rdata;
  logic [NPORT-1:0]          rvalid;
  logic [NPORT-1:0]          cs, we, oe;

  assign cs[PL] = l_cs;   assign cs[PR] = r_cs;
  assign we[PL] = l_we;   assign we[PR] = r_we;
  assign oe[PL] = l_oe;   assign oe[PR] = r_oe;
  assign addr[PL] = l_addr; assign addr[PR] = r_addr;

  dpram_arbiter #(.AW(AW)) u_arb (
    .clk(clk), .rst(rst), .slave_mode(slave_mode),
    .l_cs(l_cs), .l_we(l_we), .l_addr(l_addr),
    .r_cs(r_cs), .r_we(r_we), .r_addr(r_addr),
    .l_busy_i(l_busy_i), .r_busy_i(r_busy_i),
    .l_busy_o(l_busy_o), .r_busy_o(r_busy_o),
    .l_block(blk[PL]), .r_block(blk[PR])
  );

  dpram_core #(.AW(AW), .DW(DW)) u_core (
    .clk(clk),
    .l_wr(wr_en[PL]), .l_addr(l_addr), .l_wdata(l_wdata),
    .r_wr(wr_en[PR]), .r_addr(r_addr), .r_wdata(r_wdata),
    .l_word(word[PL]), .r_word(word[PR])
  );

  for (genvar k = 0; k < NPORT; k++) begin : g_port
    localparam int OTHER = NPORT - 1 - k;
    localparam logic [AW-1:0] MBOX = AW'(mbox_addr(k));

    assign wr_en[k]  = cs[k] && we[k] && !blk[k];
    assign rd_en[k]  = cs[k] && !we[k] && !blk[k];
    assign rd_req[k] = rd_en[k] && oe[k];

    dpram_rdport #(.DW(DW)) u_rd (
      .clk(clk), .rst(rst), .rd_req(rd_req[k]), .word(word[k]),
      .rdata(rdata[k]), .rvalid(rvalid[k])
    );

    dpram_mbox_flag u_mbox (
      .clk(clk), .rst(rst),
      .set_i(wr_en[OTHER] && (addr[OTHER] == MBOX)),
      .clr_i(rd_en[k] && (addr[k] == MBOX)),
      .flag(irq[k])
    );
  end

  assign l_rdata  = rdata[PL];
  assign r_rdata  = rdata[PR];
  assign l_rvalid = rvalid[PL];
  assign r_rvalid = rvalid[PR];
  assign l_irq    = irq[PL];
  assign r_irq    = irq[PR];
endmodule

// File: rtl/dpram_mailbox_chk.sv
module dpram_mailbox_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          slave_mode,
  input logic          l_cs,
  input logic          l_we,
  input logic          l_oe,
  input logic [AW-1:0] l_addr,
  input logic          r_cs,
  input logic          r_we,
  input logic          r_oe,
  input logic [AW-1:0] r_addr,
  input logic          l_busy_o,
  input logic          r_busy_o,
  input logic          l_rvalid,
  input logic          r_rvalid,
  input logic          l_irq,
  input logic          r_irq,
  input logic [1:0]    wr_en,
  input logic [1:0]    rd_en
);
  localparam logic [AW-1:0] MB_L = '1;
  localparam logic [AW-1:0] MB_R = MB_L - 1'b1;

  assert_busy_one_side_R4: assert property (@(posedge clk) disable iff (rst)
    !slave_mode |-> !(l_busy_o && r_busy_o));

  assert_busy_needs_write_R3: assert property (@(posedge clk) disable iff (rst)
    (l_busy_o || r_busy_o) |-> (l_cs && r_cs && (l_addr == r_addr) && (l_we || r_we)));

  assert_lvalid_after_read_R2: assert property (@(posedge clk) disable iff (rst)
    l_rvalid |-> $past(l_cs && l_oe && !l_we));

  assert_rvalid_after_read_R2: assert property (@(posedge clk) disable iff (rst)
    r_rvalid |-> $past(r_cs && r_oe && !r_we));

  assert_busy_kills_valid_R6: assert property (@(posedge clk) disable iff (rst)
    (l_busy_o || r_busy_o) |=> !(l_busy_o ? 1'b0 : 1'b0) && ($past(l_busy_o) ? !l_rvalid : !r_rvalid));

  assert_left_irq_set_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en[1] && r_addr == MB_L) |=> l_irq);

  assert_right_irq_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en[1] && r_addr == MB_R && !(wr_en[0] && l_addr == MB_R)) |=> !r_irq);

  assert_slave_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    slave_mode |-> (!l_busy_o && !r_busy_o));

  assert_idle_no_valid_R9: assert property (@(posedge clk) disable iff (rst)
    !l_cs |=> !l_rvalid);
endmodule

bind dpram_mailbox dpram_mailbox_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .slave_mode(slave_mode),
  .l_cs(l_cs), .l_we(l_we), .l_oe(l_oe), .l_addr(l_addr),
  .r_cs(r_cs), .r_we(r_we), .r_oe(r_oe), .r_addr(r_addr),
  .l_busy_o(l_busy_o), .r_busy_o(r_busy_o),
  .l_rvalid(l_rvalid), .r_rvalid(r_rvalid),
  .l_irq(l_irq), .r_irq(r_irq),
  .wr_en(wr_en), .rd_en(rd_en)
);

// File: tb/tb_dpram_mailbox.sv
`timescale 1ns/1ps
module tb_dpram_mailbox;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slave_mode = 1'b0;
  logic l_cs = 0, l_we = 0, l_oe = 0, l_busy_i = 0;
  logic r_cs = 0, r_we = 0, r_oe = 0, r_busy_i = 0;
  logic [9:0] l_addr = '0, r_addr = '0;
  logic [7:0] l_wdata = '0, r_wdata = '0;
  logic [7:0] l_rdata, r_rdata;
  logic l_rvalid, r_rvalid, l_busy_o, r_busy_o, l_irq, r_irq;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dpram_mailbox dut (.*);

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    l_cs = 0; l_we = 0; l_oe = 0; r_cs = 0; r_we = 0; r_oe = 0;
    l_busy_i = 0; r_busy_i = 0;
  endtask

  task automatic set_l(input logic cs, input logic we, input logic oe,
                       input logic [9:0] a, input logic [7:0] d);
    l_cs = cs; l_we = we; l_oe = oe; l_addr = a; l_wdata = d;
  endtask

  task automatic set_r(input logic cs, input logic we, input logic oe,
                       input logic [9:0] a, input logic [7:0] d);
    r_cs = cs; r_we = we; r_oe = oe; r_addr = a; r_wdata = d;
  endtask

  task automatic wr_l(input logic [9:0] a, input logic [7:0] d);
    idle(); set_l(1, 1, 0, a, d); tick(); idle(); tick();
  endtask

  task automatic wr_r(input logic [9:0] a, input logic [7:0] d);
    idle(); set_r(1, 1, 0, a, d); tick(); idle(); tick();
  endtask

  task automatic rd_l_chk(input string req, input logic [9:0] a, input logic [7:0] exp);
    idle(); set_l(1, 0, 1, a, 0); tick();
    check(req, l_rvalid, 1); check(req, l_rdata, exp);
    idle(); tick();
  endtask

  task automatic rd_r_chk(input string req, input logic [9:0] a, input logic [7:0] exp);
    idle(); set_r(1, 0, 1, a, 0); tick();
    check(req, r_rvalid, 1); check(req, r_rdata, exp);
    idle(); tick();
  endtask

  task automatic t_reset();
    check("R11 reset l_irq", l_irq, 0);
    check("R11 reset r_irq", r_irq, 0);
    check("R11 reset l_rvalid", l_rvalid, 0);
    check("R11 reset r_rvalid", r_rvalid, 0);
    check("R9 reset rdata", l_rdata, 0);
  endtask

  task automatic t_basic();
    wr_l(10'h055, 8'hA5);
    rd_l_chk("R2 left readback", 10'h055, 8'hA5);
    rd_r_chk("R1 right sees left write", 10'h055, 8'hA5);
    idle(); set_l(1, 1, 0, 10'h123, 8'h3C); set_r(1, 1, 0, 10'h321, 8'hC3);
    #1 check("R1 no busy different words", {l_busy_o, r_busy_o}, 0);
    tick(); idle(); tick();
    rd_r_chk("R1 left word via right", 10'h123, 8'h3C);
    rd_l_chk("R1 right word via left", 10'h321, 8'hC3);
  endtask

  task automatic t_dual_read();
    idle(); set_l(1, 0, 1, 10'h055, 0); set_r(1, 0, 1, 10'h055, 0);
    #1 check("R3 no busy dual read", {l_busy_o, r_busy_o}, 0);
    tick();
    check("R3 left valid", l_rvalid, 1); check("R3 left data", l_rdata, 8'hA5);
    check("R3 right valid", r_rvalid, 1); check("R3 right data", r_rdata, 8'hA5);
    idle(); tick();
  endtask

  task automatic t_collide_new();
    wr_l(10'h0B0, 8'h01);
    idle(); set_l(1, 1, 0, 10'h0B0, 8'h31); set_r(1, 0, 1, 10'h0B0, 0);
    #1 check("R4 right busy", r_busy_o, 1); check("R4 left free", l_busy_o, 0);
    tick();
    check("R6 right read invalid", r_rvalid, 0); check("R9 invalid data zero", r_rdata, 0);
    idle(); tick();
    rd_l_chk("R4 left write landed", 10'h0B0, 8'h31);
    idle(); set_l(1, 1, 0, 10'h0C0, 8'h44); set_r(1, 1, 0, 10'h0C0, 8'h99);
    #1 check("R4 dual write right busy", {l_busy_o, r_busy_o}, 2'b01);
    tick(); idle(); tick();
    rd_r_chk("R6 right write dropped", 10'h0C0, 8'h44);
  endtask

  task automatic t_holder();
    wr_r(10'h0A0, 8'h5A);
    idle(); set_r(1, 0, 1, 10'h0A0, 0); tick();
    set_l(1, 1, 0, 10'h0A0, 8'hEE);
    #1 check("R5 newcomer left busy", l_busy_o, 1); check("R5 holder right free", r_busy_o, 0);
    tick();
    check("R5 holder read valid", r_rvalid, 1); check("R5 holder read old", r_rdata, 8'h5A);
    idle(); tick();
    rd_l_chk("R6 left write dropped", 10'h0A0, 8'h5A);
  endtask

  task automatic t_mailbox();
    idle(); set_r(1, 1, 0, 10'h3FF, 8'h12);
    #1 check("R7 l_irq low before", l_irq, 0);
    tick(); check("R7 l_irq set", l_irq, 1); check("R8 r_irq untouched", r_irq, 0);
    idle(); tick();
    idle(); set_l(1, 0, 1, 10'h3FF, 0); tick();
    check("R7 mailbox data", l_rdata, 8'h12); check("R7 l_irq cleared", l_irq, 0);
    idle(); tick();
    idle(); set_l(1, 1, 0, 10'h3FE, 8'h34); tick();
    check("R8 r_irq set", r_irq, 1); check("R7 l_irq stays low", l_irq, 0);
    idle(); tick();
    idle(); set_r(1, 0, 0, 10'h3FE, 0); tick();
    check("R8 r_irq cleared by read", r_irq, 0);
    check("R9 oe low no valid", r_rvalid, 0); check("R9 oe low data zero", r_rdata, 0);
    idle(); tick();
  endtask

  task automatic t_idle_port();
    idle(); set_l(0, 1, 1, 10'h055, 8'hFF); set_r(1, 1, 0, 10'h055, 8'h77);
    #1 check("R9 unselected no busy", {l_busy_o, r_busy_o}, 0);
    tick(); check("R9 unselected no valid", l_rvalid, 0);
    idle(); tick();
    rd_l_chk("R9 unselected no write", 10'h055, 8'h77);
  endtask

  task automatic t_slave();
    wr_l(10'h100, 8'h66);
    idle(); slave_mode = 1; tick();
    set_l(1, 1, 0, 10'h100, 8'h77); l_busy_i = 1; tick(); idle(); tick();
    rd_r_chk("R10 busy_i blocks write", 10'h100, 8'h66);
    idle(); set_l(1, 0, 1, 10'h100, 0); l_busy_i = 1; tick();
    check("R10 busy_i invalidates read", l_rvalid, 0);
    idle(); tick();
    idle(); set_l(1, 1, 0, 10'h200, 8'h11); set_r(1, 1, 0, 10'h200, 8'h22);
    #1 check("R10 slave outputs low", {l_busy_o, r_busy_o}, 0);
    tick(); idle(); tick();
    rd_r_chk("R12 left wins dual write", 10'h200, 8'h11);
    slave_mode = 0; tick();
    idle(); set_r(1, 1, 0, 10'h100, 8'h88); r_busy_i = 1; tick(); idle(); tick();
    rd_l_chk("R10 master ignores busy_i", 10'h100, 8'h88);
  endtask

  task automatic t_reset_keep();
    wr_r(10'h3FF, 8'h56);
    check("R7 set again", l_irq, 1);
    rst = 1; tick(); rst = 0;
    check("R11 irq cleared", l_irq, 0);
    tick();
    rd_l_chk("R11 memory kept", 10'h3FF, 8'h56);
  endtask

  initial begin
    idle();
    repeat (3) tick();
    rst = 0; tick();
    t_reset();
    t_basic();
    t_dual_read();
    t_collide_new();
    t_holder();
    t_mailbox();
    t_idle_port();
    t_slave();
    t_reset_keep();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule